// File: doc/BRIEF.md
# Converter Power-State Sequencer

This block sits on the host side of a serial analog-to-digital converter that has no control register. The converter's power state is set purely by how its frames are clocked: a frame that keeps chip-select low well beyond the tenth falling clock edge returns the converter to normal operation, while a frame cut short between the second and tenth falling edges steps it one level deeper into power-down. The sequencer turns a one-cycle command into the correct run of such dummy frames. It shapes the chip-select and serial clock lines, spaces the frames with a quiet interval, and adds a wake-up delay whenever the converter may be coming out of full power-down.

A command names a target mode: normal, partial power-down or full power-down. It is either a plain transition from the mode the sequencer last set, or an after-supply initialisation, where the converter's starting mode is unknown. The sequencer keeps the last mode it set and reports it. While a sequence runs it holds `busy`. At the end it pulses `done` and updates the reported mode. Converted data is not captured. Each full frame clocks 16 edges, and a truncated frame clocks 6.

Top module: `adc_pwr_seq`

## Requirements
- R1: While reset is held and after it is released, `adc_cs_n` is 1, `adc_sclk` is 1, `busy` and `done` are 0, and `mode_o` reads full power-down (2).
- R2: `cmd_mode` encodes the target as 0 = normal, 1 = partial power-down and 2 = full power-down. A `cmd_valid` pulse with one of these codes, seen while idle, is accepted and `busy` is 1 in the following cycle. The code 3 is ignored: no frame, no `busy`, no `done`, and `mode_o` is unchanged.
- R3: An initialisation command (`cmd_init`=1) targeting normal emits exactly one full frame of 16 falling clock edges.
- R4: An initialisation command targeting partial power-down emits one full frame and then one truncated frame of 6 falling edges.
- R5: An initialisation command targeting full power-down emits one full frame and then two truncated frames.
- R6: When the last mode set is normal, a plain command emits one truncated frame for a partial target, two truncated frames for a full target, and one full frame for a normal target.
- R7: When the last mode set is a power-down mode, a plain command emits one full frame and then one truncated frame per power-down level of the target (0, 1 or 2).
- R8: `adc_sclk` is high whenever `adc_cs_n` is high. A full frame raises `adc_cs_n` after its 16th falling edge, and a truncated frame raises it after its 6th falling edge and before any 7th.
- R9: `adc_cs_n` stays high for at least QUIET_CYC clock cycles between the end of a frame and the next falling edge of `adc_cs_n`, and between the end of the last frame and `done`.
- R10: When a sequence starts from full power-down or is an initialisation, at least WAKE_CYC cycles pass from the first frame's chip-select falling edge to the next chip-select falling edge or to `done`. Otherwise no wake delay is added, and the gap after the first frame is only the quiet interval.
- R11: `busy` stays high through the whole sequence and falls in the cycle where `done` is high. `done` lasts exactly one cycle, and `mode_o` changes only in that cycle, taking the target mode.
- R12: Commands presented while `busy` is high are ignored: the running sequence is unchanged and no further frame follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_valid | input | 1 | One-cycle command strobe |
| cmd_init | input | 1 | 1 = after-supply initialisation, starting mode unknown |
| cmd_mode | input | 2 | Target mode: 0 normal, 1 partial, 2 full, 3 invalid |
| adc_cs_n | output | 1 | Converter chip-select, active low |
| adc_sclk | output | 1 | Converter serial clock, idles high |
| busy | output | 1 | High while a sequence runs |
| done | output | 1 | One-cycle pulse at the end of a sequence |
| mode_o | output | 2 | Mode set by the last completed sequence |

## Verification
Most internal faults appear on the chip-select line. A corrupted frame counter or edge counter shows up as the wrong number of chip-select low periods, or the wrong number of clock falls inside one, at the very next frame boundary. A wrong held mode does not show up in the command that stored it. It shows up one command later, as a missing or extra full frame, or as a missing wake gap, so the tests chain commands whose frame pattern depends on the previous mode. Quiet and wake counter faults shorten the chip-select high gap, which is measured within the same sequence.

// File: rtl/adc_pwr_pkg.sv
package adc_pwr_pkg;

  typedef enum logic [1:0] {
    PM_NORMAL  = 2'd0,
    PM_PARTIAL = 2'd1,
    PM_FULL    = 2'd2,
    PM_BAD     = 2'd3
  } pwr_mode_e;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_FRAME = 2'd1,
    SQ_GAP   = 2'd2
  } seq_state_e;

endpackage

// File: rtl/adc_rst_sync.sv
module adc_rst_sync (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);

  logic meta_q;
  logic hold_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      meta_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      hold_q <= meta_q;
    end
  end

  assign rst_n_o = hold_q;

endmodule

// File: rtl/adc_seq_plan.sv
// Works out the frame pattern for a command: whether a full frame
// leads, how many truncated frames follow, and whether a wake gap applies.
module adc_seq_plan
  import adc_pwr_pkg::*;
(
  input  logic       init_i,
  input  pwr_mode_e  tgt_i,
  input  pwr_mode_e  cur_i,
  output logic       full_o,
  output logic [1:0] trunc_o,
  output logic       wake_o
);

  always_comb begin
    full_o = init_i | (cur_i != PM_NORMAL) | (tgt_i == PM_NORMAL);
    case (tgt_i)
      PM_PARTIAL: trunc_o = 2'd1;
      PM_FULL:    trunc_o = 2'd2;
      default:    trunc_o = 2'd0;
    endcase
    wake_o = full_o & (init_i | (cur_i == PM_FULL));
  end

endmodule

// File: rtl/adc_sclk_gen.sv
// Serial clock for one frame: divides the system clock, counts falling
// edges and flags the half period at which chip-select must rise.
module adc_sclk_gen #(
  parameter int HALF_DIV    = 3,
  parameter int FULL_EDGES  = 16,
  parameter int TRUNC_EDGES = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic run_i,
  input  logic full_i,
  output logic sclk_o,
  output logic end_o
);

  localparam int EW = $clog2(FULL_EDGES + 1);
  localparam logic [EW-1:0] FULL_LIM  = EW'(FULL_EDGES);
  localparam logic [EW-1:0] TRUNC_LIM = EW'(TRUNC_EDGES);

  logic          tick;
  logic          sclk_q, sclk_d;
  logic [EW-1:0] ec_q, ec_d;
  logic [EW-1:0] lim;

  generate
    if (HALF_DIV == 1) begin : g_nodiv
      assign tick = run_i;
    end else begin : g_div
      localparam int HW = $clog2(HALF_DIV);
      localparam logic [HW-1:0] HLAST = HW'(HALF_DIV - 1);
      logic [HW-1:0] hc_q, hc_d;

      always_comb begin
        hc_d = hc_q;
        if (start_i) begin
          hc_d = '0;
        end else if (run_i) begin
          hc_d = (hc_q == HLAST) ? '0 : hc_q + 1'b1;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          hc_q <= '0;
        end else begin
          hc_q <= hc_d;
        end
      end

      assign tick = run_i & (hc_q == HLAST);
    end
  endgenerate

  assign lim   = full_i ? FULL_LIM : TRUNC_LIM;
  assign end_o = tick & sclk_q & (ec_q == lim);

  always_comb begin
    sclk_d = sclk_q;
    ec_d   = ec_q;
    if (start_i) begin
      sclk_d = 1'b1;
      ec_d   = '0;
    end else if (tick && !end_o) begin
      if (sclk_q) begin
        sclk_d = 1'b0;
        ec_d   = ec_q + 1'b1;
      end else begin
        sclk_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b1;
      ec_q   <= '0;
    end else begin
      sclk_q <= sclk_d;
      ec_q   <= ec_d;
    end
  end

  assign sclk_o = sclk_q;

endmodule

// File: rtl/adc_gap_timer.sv
// Quiet-interval counter (restarted when chip-select rises) and wake
// counter (armed when the first full frame's chip-select falls).
module adc_gap_timer #(
  parameter int QUIET_CYC = 4,
  parameter int WAKE_CYC  = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic gap_start_i,
  input  logic arm_i,
  input  logic clear_i,
  output logic quiet_ok_o,
  output logic wake_ok_o
);

  localparam int QW = $clog2(QUIET_CYC + 1);
  localparam int WW = $clog2(WAKE_CYC + 1);
  localparam logic [QW-1:0] QLAST = QW'(QUIET_CYC - 1);
  localparam logic [WW-1:0] WLAST = WW'(WAKE_CYC - 1);

  logic [QW-1:0] qc_q, qc_d;
  logic [WW-1:0] wk_q, wk_d;
  logic          armed_q, armed_d;

  always_comb begin
    qc_d = qc_q;
    if (gap_start_i) begin
      qc_d = '0;
    end else if (qc_q != QLAST) begin
      qc_d = qc_q + 1'b1;
    end
  end

  always_comb begin
    wk_d    = wk_q;
    armed_d = armed_q;
    if (arm_i) begin
      wk_d    = '0;
      armed_d = 1'b1;
    end else if (clear_i) begin
      armed_d = 1'b0;
    end else if (armed_q && (wk_q != WLAST)) begin
      wk_d = wk_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      qc_q    <= '0;
      wk_q    <= '0;
      armed_q <= 1'b0;
    end else begin
      qc_q    <= qc_d;
      wk_q    <= wk_d;
      armed_q <= armed_d;
    end
  end

  assign quiet_ok_o = (qc_q == QLAST);
  assign wake_ok_o  = !armed_q || (wk_q == WLAST);

endmodule

// File: rtl/adc_pwr_seq.sv
module adc_pwr_seq
  import adc_pwr_pkg::*;
#(
  parameter int HALF_DIV    = 3,
  parameter int FULL_EDGES  = 16,
  parameter int TRUNC_EDGES = 6,
  parameter int QUIET_CYC   = 4,
  parameter int WAKE_CYC    = 200
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic       cmd_init,
  input  logic [1:0] cmd_mode,
  output logic       adc_cs_n,
  output logic       adc_sclk,
  output logic       busy,
  output logic       done,
  output logic [1:0] mode_o
);

  logic       rst_q_n;
  seq_state_e state_q, state_d;
  logic       cs_q, cs_d;
  logic [1:0] trunc_q, trunc_d;
  logic       cur_full_q, cur_full_d;
  pwr_mode_e  tgt_q, tgt_d;
  pwr_mode_e  mode_q, mode_d;
  logic       done_q, done_d;

  logic       plan_full, plan_wake;
  logic [1:0] plan_trunc;
  logic       frame_start, gap_start, wake_arm, wake_clear;
  logic       frame_end, quiet_ok, wake_ok;
  logic       accept;
  pwr_mode_e  cmd_tgt;

  assign cmd_tgt = pwr_mode_e'(cmd_mode);
  assign accept  = (state_q == SQ_IDLE) && cmd_valid && (cmd_tgt != PM_BAD);

  adc_rst_sync u_rst (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_q_n)
  );

  adc_seq_plan u_plan (
    .init_i  (cmd_init),
    .tgt_i   (cmd_tgt),
    .cur_i   (mode_q),
    .full_o  (plan_full),
    .trunc_o (plan_trunc),
    .wake_o  (plan_wake)
  );

  adc_sclk_gen #(
    .HALF_DIV    (HALF_DIV),
    .FULL_EDGES  (FULL_EDGES),
    .TRUNC_EDGES (TRUNC_EDGES)
  ) u_sclk (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .start_i (frame_start),
    .run_i   (state_q == SQ_FRAME),
    .full_i  (cur_full_q),
    .sclk_o  (adc_sclk),
    .end_o   (frame_end)
  );

  adc_gap_timer #(
    .QUIET_CYC (QUIET_CYC),
    .WAKE_CYC  (WAKE_CYC)
  ) u_gap (
    .clk         (clk),
    .rst_n       (rst_q_n),
    .gap_start_i (gap_start),
    .arm_i       (wake_arm),
    .clear_i     (wake_clear),
    .quiet_ok_o  (quiet_ok),
    .wake_ok_o   (wake_ok)
  );

  // Next-state logic
  always_comb begin
    state_d     = state_q;
    cs_d        = cs_q;
    trunc_d     = trunc_q;
    cur_full_d  = cur_full_q;
    tgt_d       = tgt_q;
    mode_d      = mode_q;
    done_d      = 1'b0;
    frame_start = 1'b0;
    gap_start   = 1'b0;
    wake_arm    = 1'b0;
    wake_clear  = 1'b0;
    case (state_q)
      SQ_IDLE: begin
        if (accept) begin
          tgt_d       = cmd_tgt;
          cur_full_d  = plan_full;
          trunc_d     = plan_full ? plan_trunc : plan_trunc - 2'd1;
          wake_arm    = plan_wake;
          frame_start = 1'b1;
          cs_d        = 1'b0;
          state_d     = SQ_FRAME;
        end
      end
      SQ_FRAME: begin
        if (frame_end) begin
          cs_d      = 1'b1;
          gap_start = 1'b1;
          state_d   = SQ_GAP;
        end
      end
      SQ_GAP: begin
        if (quiet_ok && wake_ok) begin
          wake_clear = 1'b1;
          if (trunc_q != 2'd0) begin
            trunc_d     = trunc_q - 2'd1;
            cur_full_d  = 1'b0;
            frame_start = 1'b1;
            cs_d        = 1'b0;
            state_d     = SQ_FRAME;
          end else begin
            mode_d  = tgt_q;
            done_d  = 1'b1;
            state_d = SQ_IDLE;
          end
        end
      end
      default: state_d = SQ_IDLE;
    endcase
  end

  // State registers
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      state_q    <= SQ_IDLE;
      cs_q       <= 1'b1;
      trunc_q    <= 2'd0;
      cur_full_q <= 1'b1;
      tgt_q      <= PM_FULL;
      mode_q     <= PM_FULL;
      done_q     <= 1'b0;
    end else begin
      state_q    <= state_d;
      cs_q       <= cs_d;
      trunc_q    <= trunc_d;
      cur_full_q <= cur_full_d;
      tgt_q      <= tgt_d;
      mode_q     <= mode_d;
      done_q     <= done_d;
    end
  end

  assign adc_cs_n = cs_q;
  assign busy     = (state_q != SQ_IDLE);
  assign done     = done_q;
  assign mode_o   = mode_q;

endmodule

// File: rtl/adc_pwr_seq_chk.sv
module adc_pwr_seq_chk #(
  parameter int FULL_EDGES  = 16,
  parameter int TRUNC_EDGES = 6,
  parameter int QUIET_CYC   = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic       sclk,
  input logic       busy,
  input logic       done,
  input logic [1:0] mode
);

  int   fall_cnt;
  int   high_cnt;
  logic sclk_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fall_cnt <= 0;
      high_cnt <= QUIET_CYC;
      sclk_p   <= 1'b1;
    end else begin
      sclk_p <= sclk;
      if (cs_n) begin
        fall_cnt <= 0;
        if (high_cnt < QUIET_CYC) high_cnt <= high_cnt + 1;
      end else begin
        high_cnt <= 0;
        if (sclk_p && !sclk) fall_cnt <= fall_cnt + 1;
      end
    end
  end

  AST_SCLK_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> sclk);  // R8
  AST_FRAME_EDGES: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> ((fall_cnt == FULL_EDGES) || (fall_cnt == TRUNC_EDGES)));  // R8
  AST_QUIET_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> (high_cnt >= QUIET_CYC));  // R9
  AST_CS_LOW_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> busy);  // R11
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);  // R11
  AST_BUSY_END_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);  // R11
  AST_MODE_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != $past(mode)) |-> done);  // R11

endmodule

bind adc_pwr_seq adc_pwr_seq_chk #(
  .FULL_EDGES  (FULL_EDGES),
  .TRUNC_EDGES (TRUNC_EDGES),
  .QUIET_CYC   (QUIET_CYC)
) chk_i (
  .clk  (clk),
  .rst_n(rst_q_n),
  .cs_n (adc_cs_n),
  .sclk (adc_sclk),
  .busy (busy),
  .done (done),
  .mode (mode_o)
);

// File: tb/adc_pwr_seq_tb.sv
`timescale 1ns/1ps
module adc_pwr_seq_tb_top;

  localparam int HALF  = 3;
  localparam int QUIET = 4;
  localparam int WAKE  = 200;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic       cmd_init = 1'b0;
  logic [1:0] cmd_mode = 2'd0;
  logic       adc_cs_n, adc_sclk, busy, done;
  logic [1:0] mode_o;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  adc_pwr_seq #(
    .HALF_DIV (HALF),
    .QUIET_CYC(QUIET),
    .WAKE_CYC (WAKE)
  ) dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_valid(cmd_valid),
    .cmd_init (cmd_init),
    .cmd_mode (cmd_mode),
    .adc_cs_n (adc_cs_n),
    .adc_sclk (adc_sclk),
    .busy     (busy),
    .done     (done),
    .mode_o   (mode_o)
  );

  // Port monitor, sampled on the falling clock edge
  int   cyc = 0;
  logic p_cs = 1'b1, p_sclk = 1'b1;
  int   nf = 0, cur_e = 0, done_n = 0, done_t = 0, stray = 0, busy_bad = 0;
  int   edges_a [0:7];
  int   fall_t  [0:7];
  int   rise_t  [0:7];

  always @(negedge clk) begin
    cyc++;
    if (p_cs && !adc_cs_n) begin
      if (nf < 8) fall_t[nf] = cyc;
      cur_e = 0;
    end
    if (!adc_cs_n && p_sclk && !adc_sclk) cur_e++;
    if (!p_cs && adc_cs_n) begin
      if (nf < 8) begin
        edges_a[nf] = cur_e;
        rise_t[nf]  = cyc;
      end
      nf++;
    end
    if (adc_cs_n && (adc_sclk != p_sclk)) stray++;
    if (!adc_cs_n && !busy) busy_bad++;
    if (done) begin
      done_n++;
      done_t = cyc;
    end
    p_cs   = adc_cs_n;
    p_sclk = adc_sclk;
  end

  task automatic chk(input string req, input bit ok, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_mon();
    nf = 0; cur_e = 0; done_n = 0; stray = 0; busy_bad = 0;
  endtask

  task automatic issue(input bit init, input logic [1:0] md);
    @(posedge clk); #1;
    clear_mon();
    cmd_valid = 1'b1; cmd_init = init; cmd_mode = md;
    @(posedge clk); #1;
    cmd_valid = 1'b0; cmd_init = 1'b0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 6000 && done_n == 0; i++) @(posedge clk);
    repeat (10) @(posedge clk);
    #1;
  endtask

  // Runs one command and checks frame pattern, gaps, busy/done and mode.
  task automatic run_case(input string req, input bit init, input logic [1:0] md,
                          input int exp_n, input int e0, input int e1, input int e2,
                          input bit exp_wake, input int exp_mode);
    int exp_e [0:2];
    int min_gap;
    int t_end;
    exp_e[0] = e0; exp_e[1] = e1; exp_e[2] = e2;
    issue(init, md);
    chk("R2 busy after accept", busy == 1'b1, busy, 1);
    wait_done();
    chk({req, " frame count"}, nf == exp_n, nf, exp_n);
    if (nf == exp_n) begin
      for (int i = 0; i < exp_n; i++)
        chk({req, " R8 edges per frame"}, edges_a[i] == exp_e[i], edges_a[i], exp_e[i]);
      min_gap = done_t - rise_t[exp_n-1];
      for (int i = 0; i + 1 < exp_n; i++)
        if (fall_t[i+1] - rise_t[i] < min_gap) min_gap = fall_t[i+1] - rise_t[i];
      chk("R9 quiet gap", min_gap >= QUIET, min_gap, QUIET);
      t_end = (exp_n > 1) ? fall_t[1] : done_t;
      if (exp_wake)
        chk("R10 wake delay present", (t_end - fall_t[0]) >= WAKE, t_end - fall_t[0], WAKE);
      else
        chk("R10 no wake delay", (t_end - rise_t[0]) <= QUIET + 2, t_end - rise_t[0], QUIET);
    end
    chk("R11 single done", done_n == 1, done_n, 1);
    chk("R11 busy idle after", busy == 1'b0, busy, 0);
    chk("R11 busy over frames", busy_bad == 0, busy_bad, 0);
    chk("R8 sclk idle high", stray == 0, stray, 0);
    chk({req, " mode"}, int'(mode_o) == exp_mode, mode_o, exp_mode);
  endtask

  task automatic case_reset();
    rst_n = 1'b0;
    repeat (4) @(posedge clk);
    #1;
    chk("R1 cs in reset", adc_cs_n == 1'b1, adc_cs_n, 1);
    chk("R1 sclk in reset", adc_sclk == 1'b1, adc_sclk, 1);
    chk("R1 busy in reset", busy == 1'b0, busy, 0);
    chk("R1 done in reset", done == 1'b0, done, 0);
    chk("R1 mode in reset", mode_o == 2'd2, mode_o, 2);
    rst_n = 1'b1;
    repeat (6) @(posedge clk);
    #1;
    chk("R1 idle after release", adc_cs_n && adc_sclk && !busy, busy, 0);
  endtask

  task automatic case_bad_code();
    issue(1'b0, 2'd3);
    chk("R2 code 3 not busy", busy == 1'b0, busy, 0);
    repeat (60) @(posedge clk);
    #1;
    chk("R2 code 3 no frame", nf == 0, nf, 0);
    chk("R2 code 3 no done", done_n == 0, done_n, 0);
    chk("R2 code 3 mode kept", mode_o == 2'd2, mode_o, 2);
  endtask

  task automatic case_busy_ignore();
    issue(1'b1, 2'd2);
    repeat (20) @(posedge clk);
    #1;
    cmd_valid = 1'b1; cmd_init = 1'b0; cmd_mode = 2'd0;
    @(posedge clk); #1;
    cmd_valid = 1'b0;
    wait_done();
    chk("R12 frames unchanged", nf == 3, nf, 3);
    if (nf == 3) chk("R12 last frame truncated", edges_a[2] == 6, edges_a[2], 6);
    chk("R12 mode unchanged", mode_o == 2'd2, mode_o, 2);
    repeat (300) @(posedge clk);
    #1;
    chk("R12 no later frame", nf == 3, nf, 3);
    chk("R12 idle after", busy == 1'b0, busy, 0);
  endtask

  initial begin
    case_reset();
    case_bad_code();
    run_case("R3 init normal",         1'b1, 2'd0, 1, 16, 0, 0, 1'b1, 0);
    run_case("R6 normal to normal",    1'b0, 2'd0, 1, 16, 0, 0, 1'b0, 0);
    run_case("R6 normal to partial",   1'b0, 2'd1, 1, 6, 0, 0, 1'b0, 1);
    run_case("R7 partial to normal",   1'b0, 2'd0, 1, 16, 0, 0, 1'b0, 0);
    run_case("R6 normal to full",      1'b0, 2'd2, 2, 6, 6, 0, 1'b0, 2);
    run_case("R7 full to normal",      1'b0, 2'd0, 1, 16, 0, 0, 1'b1, 0);
    run_case("R4 init partial",        1'b1, 2'd1, 2, 16, 6, 0, 1'b1, 1);
    run_case("R7 partial to partial",  1'b0, 2'd1, 2, 16, 6, 0, 1'b0, 1);
    run_case("R5 init full",           1'b1, 2'd2, 3, 16, 6, 6, 1'b1, 2);
    run_case("R7 full to full",        1'b0, 2'd2, 3, 16, 6, 6, 1'b1, 2);
    case_busy_ignore();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual %0d expected %0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule